// File: doc/BRIEF.md
# Trace Flush and Stop Controller

This block sits between an upstream trace source and a trace formatter. It collects flush requests from three origins (an external flush input, a trigger event and a manual request from a control register). It holds each accepted request until it has been served, and hands the requests to the formatter one at a time in a fixed order. The external flush input is acknowledged once its flush has finished.

The block also stops the trace stream, either when a flush completes or when a trigger arrives. A stopped controller keeps accepting upstream beats and drops them, so devices that share the upstream path never stall. When it is not stopped, the upstream valid/data/ready handshake passes straight through to the formatter. A two-bit formatting mode is resolved to a single effective setting. In bypass, no flushes are requested.

Top module: `flush_stop_ctrl`

## Requirements
- R1: When more than one source is pending and the controller is idle, the grant goes to the external flush input first, then to the trigger, then to the manual request. `flush_src_o` encodes these as 0, 1 and 2.
- R2: Only one flush is in progress at a time. While `flush_req_o` is high and `flush_done_i` is low, `flush_req_o` and `flush_src_o` hold, even if a higher-priority request arrives.
- R3: A strobe whose source enable is high is latched as pending and is granted one cycle after being latched. A pending source is cleared when its flush completes. A strobe whose source enable is low is ignored.
- R4: While the formatting mode is bypass (`fmt_mode_i` = 2'b00), flush strobes are not latched and produce no flush, even after the mode is changed later.
- R5: `fmt_mode_o` equals `fmt_mode_i`, except that 2'b11 resolves to 2'b10.
- R6: `flushin_ack_o` is a one-cycle pulse. It appears in the cycle after `flush_done_i` is sampled high for a flush of source 0, and never for the other sources.
- R7: A completed flush sets `stopped_o` in the cycle after completion, only if `stop_on_flush_i` was high at the clock edge that granted that flush. Enabling it after the grant has no effect on that flush.
- R8: A trigger strobe with `stop_on_trig_i` high sets `stopped_o` in the next cycle, whatever the trigger flush enable is.
- R9: While stopped, `up_ready_o` is high and `dn_valid_o` is low, so upstream beats are accepted and dropped.
- R10: `stopped_o` stays high until both stop enables are low (then it clears at the next edge) or until reset.
- R11: While not stopped, `dn_valid_o` follows `up_valid_i`, `dn_data_o` follows `up_data_i`, and `up_ready_o` follows `dn_ready_i`.
- R12: After reset there is no flush request, no acknowledge, no pending request and no stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_flush_i | input | 1 | External flush strobe |
| trig_i | input | 1 | Trigger strobe |
| man_flush_i | input | 1 | Manual flush strobe from a register write |
| en_ext_i | input | 1 | Flush-on-external-input enable |
| en_trig_i | input | 1 | Flush-on-trigger enable |
| en_man_i | input | 1 | Manual flush enable |
| stop_on_flush_i | input | 1 | Stop when a flush completes |
| stop_on_trig_i | input | 1 | Stop on a trigger |
| fmt_mode_i | input | 2 | Formatting mode bits, 00 = bypass |
| flush_done_i | input | 1 | Formatter reports the current flush finished |
| up_valid_i | input | 1 | Upstream beat valid |
| up_data_i | input | DATA_W | Upstream beat data |
| dn_ready_i | input | 1 | Formatter ready for a beat |
| flush_req_o | output | 1 | Flush in progress / request to formatter |
| flush_src_o | output | 2 | Source being served (0 ext, 1 trig, 2 manual) |
| flushin_ack_o | output | 1 | Acknowledge pulse for the external flush input |
| stopped_o | output | 1 | Trace stream stopped |
| fmt_mode_o | output | 2 | Resolved formatting mode |
| up_ready_o | output | 1 | Ready to upstream |
| dn_valid_o | output | 1 | Beat valid to formatter |
| dn_data_o | output | DATA_W | Beat data to formatter |

## Verification
Assertions check on every cycle that a flush being served holds its source until done, that grants respect the priority order against the pending set, that the acknowledge is a lone pulse following an external completion, and that a stopped controller keeps ready high with nothing forwarded and keeps its stop while an enable remains set. The bench scenarios show what depends on sequences of stimulus: the order of three back-to-back flushes, a late high-priority request waiting behind a running one, strobes dropped in bypass or while disabled, and the difference between a stop enable set before the grant and one set after it.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_TRIG = 2'd1,
    SRC_MAN  = 2'd2
  } src_e;

  // Fixed-order pick over the pending set: lowest index wins.
  function automatic src_e pick_src(input logic [NUM_SRC-1:0] pend);
    if (pend[0])      return SRC_EXT;
    else if (pend[1]) return SRC_TRIG;
    else              return SRC_MAN;
  endfunction

  // Two formatting bits: both set behaves as the upper bit alone.
  function automatic logic [1:0] resolve_mode(input logic [1:0] m);
    return m[1] ? 2'b10 : m;
  endfunction
endpackage

// File: rtl/fsc_flush_arb.sv
module fsc_flush_arb
  import fsc_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            done_i,
  input  logic            stop_arm_i,
  output logic            busy_o,
  output src_e            src_o,
  output logic            cmp_o,
  output logic            arm_o
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr;
  logic            grant;
  logic            busy;
  src_e            cur;
  logic            arm;

  assign cmp_o = busy & done_i;
  assign grant = !busy && (|pend);

  for (genvar g = 0; g < NSRC; g++) begin : g_pend
    assign clr[g] = cmp_o && (int'(cur) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= (pend[g] & ~clr[g]) | req_i[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= SRC_EXT;
      arm  <= 1'b0;
    end else begin
      if (busy) busy <= !done_i;
      else      busy <= |pend;
      if (grant) begin
        cur <= pick_src(pend);
        arm <= stop_arm_i;
      end
    end
  end

  assign busy_o = busy;
  assign src_o  = cur;
  assign arm_o  = arm;

  // R2: a flush being served keeps its source until done
  a_r2_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_i |=> busy && $stable(cur));

  // R1: a trigger or manual grant implies no external request was pending
  a_r1_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && cur != SRC_EXT |-> !$past(pend[0]));

  // R1: a manual grant implies no trigger request was pending
  a_r1_trig_before_man: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && cur == SRC_MAN |-> !$past(pend[1]));

  // R3: completion clears the served source unless re-requested
  a_r3_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_o && cur == SRC_MAN && !req_i[2] |=> !pend[2]);
endmodule

// File: rtl/fsc_stop_ctl.sv
module fsc_stop_ctl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_i,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              stop_on_flush_i,
  input  logic              stop_on_trig_i,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              dn_ready_i,
  output logic              stopped_o,
  output logic              up_ready_o,
  output logic              dn_valid_o,
  output logic [DATA_W-1:0] dn_data_o
);
  logic stopped;
  logic stop_evt;
  logic stop_keep;

  assign stop_evt  = (cmp_i & arm_i) | (trig_i & stop_on_trig_i);
  assign stop_keep = stop_on_flush_i | stop_on_trig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stopped <= 1'b0;
    else        stopped <= (stopped | stop_evt) & stop_keep;
  end

  assign stopped_o  = stopped;
  assign up_ready_o = stopped ? 1'b1 : dn_ready_i;
  assign dn_valid_o = up_valid_i & !stopped;
  assign dn_data_o  = up_data_i;

  // R9: stopped means accept-and-drop
  a_r9_discard: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o |-> up_ready_o && !dn_valid_o);

  // R10: stop is sticky while any stop enable remains set
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o && (stop_on_flush_i || stop_on_trig_i) |=> stopped_o);

  // R10: both enables low releases the stop
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_on_flush_i && !stop_on_trig_i |=> !stopped_o);
endmodule

// File: rtl/flush_stop_ctrl.sv
module flush_stop_ctrl
  import fsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_flush_i,
  input  logic              trig_i,
  input  logic              man_flush_i,
  input  logic              en_ext_i,
  input  logic              en_trig_i,
  input  logic              en_man_i,
  input  logic              stop_on_flush_i,
  input  logic              stop_on_trig_i,
  input  logic [1:0]        fmt_mode_i,
  input  logic              flush_done_i,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              dn_ready_i,
  output logic              flush_req_o,
  output logic [1:0]        flush_src_o,
  output logic              flushin_ack_o,
  output logic              stopped_o,
  output logic [1:0]        fmt_mode_o,
  output logic              up_ready_o,
  output logic              dn_valid_o,
  output logic [DATA_W-1:0] dn_data_o
);
  logic               fmt_on;
  logic [NUM_SRC-1:0] src_req;
  logic               busy;
  src_e               cur_src;
  logic               cmp;
  logic               arm;
  logic               ack_q;

  assign fmt_mode_o = resolve_mode(fmt_mode_i);
  assign fmt_on     = |fmt_mode_i;
  assign src_req    = {man_flush_i & en_man_i,
                       trig_i      & en_trig_i,
                       ext_flush_i & en_ext_i} & {NUM_SRC{fmt_on}};

  fsc_flush_arb #(.NSRC(NUM_SRC)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (src_req),
    .done_i     (flush_done_i),
    .stop_arm_i (stop_on_flush_i),
    .busy_o     (busy),
    .src_o      (cur_src),
    .cmp_o      (cmp),
    .arm_o      (arm)
  );

  fsc_stop_ctl #(.DATA_W(DATA_W)) u_stop (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmp_i           (cmp),
    .arm_i           (arm),
    .trig_i          (trig_i),
    .stop_on_flush_i (stop_on_flush_i),
    .stop_on_trig_i  (stop_on_trig_i),
    .up_valid_i      (up_valid_i),
    .up_data_i       (up_data_i),
    .dn_ready_i      (dn_ready_i),
    .stopped_o       (stopped_o),
    .up_ready_o      (up_ready_o),
    .dn_valid_o      (dn_valid_o),
    .dn_data_o       (dn_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= cmp && (cur_src == SRC_EXT);
  end

  assign flush_req_o   = busy;
  assign flush_src_o   = cur_src;
  assign flushin_ack_o = ack_q;

  // R6: acknowledge never lasts two cycles
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    flushin_ack_o |=> !flushin_ack_o);

  // R6: acknowledge only follows an external-source completion
  a_r6_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flushin_ack_o |-> $past(flush_req_o && flush_done_i && flush_src_o == 2'd0));
endmodule

// File: tb/flush_stop_ctrl_bench.sv
module flush_stop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_flush_i = 0, trig_i = 0, man_flush_i = 0;
  logic          en_ext_i = 0, en_trig_i = 0, en_man_i = 0;
  logic          stop_on_flush_i = 0, stop_on_trig_i = 0;
  logic [1:0]    fmt_mode_i = 2'b00;
  logic          flush_done_i = 0, up_valid_i = 0, dn_ready_i = 0;
  logic [DW-1:0] up_data_i = '0;
  logic          flush_req_o, flushin_ack_o, stopped_o, up_ready_o, dn_valid_o;
  logic [1:0]    flush_src_o, fmt_mode_o;
  logic [DW-1:0] dn_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flush_stop_ctrl #(.DATA_W(DW)) u_flush_stop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext_flush_i(ext_flush_i), .trig_i(trig_i), .man_flush_i(man_flush_i),
    .en_ext_i(en_ext_i), .en_trig_i(en_trig_i), .en_man_i(en_man_i),
    .stop_on_flush_i(stop_on_flush_i), .stop_on_trig_i(stop_on_trig_i),
    .fmt_mode_i(fmt_mode_i), .flush_done_i(flush_done_i),
    .up_valid_i(up_valid_i), .up_data_i(up_data_i), .dn_ready_i(dn_ready_i),
    .flush_req_o(flush_req_o), .flush_src_o(flush_src_o),
    .flushin_ack_o(flushin_ack_o), .stopped_o(stopped_o),
    .fmt_mode_o(fmt_mode_o), .up_ready_o(up_ready_o),
    .dn_valid_o(dn_valid_o), .dn_data_o(dn_data_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Expect a granted flush of the given source, then complete it.
  task automatic serve(input string tag, input logic [1:0] src);
    check({tag, " req"}, flush_req_o, 1'b1);
    check({tag, " src"}, flush_src_o, src);
    flush_done_i = 1'b1;
    tick();
    flush_done_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 req", flush_req_o, 1'b0);
    check("R12 ack", flushin_ack_o, 1'b0);
    check("R12 stopped", stopped_o, 1'b0);
    tick();
    check("R12 no pending grant", flush_req_o, 1'b0);
  endtask

  task automatic t_ext_ack();
    fmt_mode_i = 2'b01; en_ext_i = 1;
    ext_flush_i = 1; tick(); ext_flush_i = 0;
    check("R3 latched not yet granted", flush_req_o, 1'b0);
    tick();
    serve("R3 ext grant", 2'd0);
    check("R3 cleared after done", flush_req_o, 1'b0);
    check("R6 ack pulse", flushin_ack_o, 1'b1);
    tick();
    check("R6 ack one cycle", flushin_ack_o, 1'b0);
    check("R3 no regrant", flush_req_o, 1'b0);
  endtask

  task automatic t_priority();
    en_ext_i = 1; en_trig_i = 1; en_man_i = 1; fmt_mode_i = 2'b10;
    ext_flush_i = 1; trig_i = 1; man_flush_i = 1; tick();
    ext_flush_i = 0; trig_i = 0; man_flush_i = 0;
    tick();
    serve("R1 first ext", 2'd0);
    check("R6 ack after ext", flushin_ack_o, 1'b1);
    tick();
    serve("R1 second trig", 2'd1);
    check("R6 no ack for trig", flushin_ack_o, 1'b0);
    tick();
    serve("R1 third man", 2'd2);
    check("R6 no ack for man", flushin_ack_o, 1'b0);
    tick();
    check("R1 all served", flush_req_o, 1'b0);
  endtask

  task automatic t_inprogress();
    man_flush_i = 1; tick(); man_flush_i = 0;
    tick();
    check("R2 man running", flush_src_o, 2'd2);
    ext_flush_i = 1; tick(); ext_flush_i = 0;
    check("R2 still man", flush_src_o, 2'd2);
    check("R2 still busy", flush_req_o, 1'b1);
    tick();
    serve("R2 man completes first", 2'd2);
    tick();
    serve("R2 ext after", 2'd0);
    tick();
  endtask

  task automatic t_disabled();
    en_trig_i = 0;
    trig_i = 1; tick(); trig_i = 0;
    tick(); tick();
    check("R3 disabled source ignored", flush_req_o, 1'b0);
    en_trig_i = 1;
  endtask

  task automatic t_bypass();
    fmt_mode_i = 2'b00;
    ext_flush_i = 1; man_flush_i = 1; tick();
    ext_flush_i = 0; man_flush_i = 0; fmt_mode_i = 2'b01;
    tick(); tick();
    check("R4 bypass drops strobes", flush_req_o, 1'b0);
  endtask

  task automatic t_mode();
    fmt_mode_i = 2'b11; #1;
    check("R5 both bits", fmt_mode_o, 2'b10);
    fmt_mode_i = 2'b01; #1;
    check("R5 low bit", fmt_mode_o, 2'b01);
    fmt_mode_i = 2'b00; #1;
    check("R5 bypass", fmt_mode_o, 2'b00);
    fmt_mode_i = 2'b01;
    tick();
  endtask

  task automatic t_stop_flush();
    stop_on_flush_i = 1;
    man_flush_i = 1; tick(); man_flush_i = 0;
    tick();
    check("R7 not stopped while running", stopped_o, 1'b0);
    serve("R7 man", 2'd2);
    check("R7 stopped after done", stopped_o, 1'b1);
    up_valid_i = 1; dn_ready_i = 0; up_data_i = 32'h1234_5678; #1;
    check("R9 ready while stopped", up_ready_o, 1'b1);
    check("R9 dropped", dn_valid_o, 1'b0);
    tick();
    check("R10 sticky", stopped_o, 1'b1);
    stop_on_flush_i = 0; tick();
    check("R10 released", stopped_o, 1'b0);
    up_valid_i = 0;
  endtask

  task automatic t_stop_arm_late();
    man_flush_i = 1; tick(); man_flush_i = 0;
    tick();
    stop_on_flush_i = 1;
    serve("R7 late arm man", 2'd2);
    check("R7 late enable no stop", stopped_o, 1'b0);
    stop_on_flush_i = 0; tick();
  endtask

  task automatic t_stop_trig();
    en_trig_i = 0; stop_on_trig_i = 1;
    trig_i = 1; tick(); trig_i = 0;
    check("R8 stopped on trigger", stopped_o, 1'b1);
    check("R8 no flush while disabled", flush_req_o, 1'b0);
    stop_on_trig_i = 0; tick();
    check("R10 trig stop released", stopped_o, 1'b0);
    en_trig_i = 1;
  endtask

  task automatic t_pass();
    up_valid_i = 1; up_data_i = 32'hA5A5_0F0F; dn_ready_i = 1; #1;
    check("R11 valid", dn_valid_o, 1'b1);
    check("R11 data", dn_data_o, 32'hA5A5_0F0F);
    check("R11 ready", up_ready_o, 1'b1);
    dn_ready_i = 0; #1;
    check("R11 backpressure", up_ready_o, 1'b0);
    up_valid_i = 0; #1;
    check("R11 idle", dn_valid_o, 1'b0);
    tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ext_ack();
    t_priority();
    t_inprogress();
    t_disabled();
    t_bypass();
    t_mode();
    t_stop_flush();
    t_stop_arm_late();
    t_stop_trig();
    t_pass();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule